// File: doc/BRIEF.md
# Dual-Issue Tomasulo Scheduler Core

This block schedules a two-wide stream of integer register-to-register operations onto a pipelined adder and a pipelined multiplier. It lets them complete out of program order while keeping true data dependences. Each cycle, up to two instructions are placed into reservation stations of the matching kind. Each source operand is taken either as a value from the register file or as the tag of the station that will produce it. A station's number plus one serves as its result tag, and tag value zero means "no producer".

Finished results leave on two result buses. The adder drives bus 0 and the multiplier drives bus 1, so both can deliver in the same cycle. A broadcast wakes every station waiting on that tag. It also updates the register file entry whose pending-producer tag still matches, and that update appears on the commit-write outputs. Program order holds only at dispatch: a younger instruction never enters a station while an older one in the same pair is held back.

A surrounding front end presents instructions on the two slots. It retires those reported in `taken` and presents the rest again in the next cycle. The register file leaves reset holding its own index in every entry (register i = i).

Top module: `tomo_core`

## Requirements
- R1: Reset returns every register to the value equal to its index with no pending producer, empties all stations and execution pipelines, and leaves no broadcast of work dispatched before reset.
- R2: A valid slot is taken when a free station of its kind exists (`in_op` 0 = add, 1 = multiply). Slot 1 is taken only if slot 0 is taken or invalid. `stall` is high exactly when some valid slot is not taken.
- R3: An add whose operands are available at dispatch in cycle D commits on bus 0 in cycle D+2, with the sum truncated to the data width.
- R4: A multiply whose operands are available at dispatch in cycle D commits on bus 1 in cycle D+3, with the low data-width bits of the product.
- R5: A station waiting on a tag captures the value in the cycle that tag is broadcast and can start executing in that same cycle. A source whose producer broadcasts during the dispatch cycle is taken as a value.
- R6: When slot 1 reads the register that slot 0 of the same cycle writes, slot 1 waits on slot 0's tag rather than reading the old register value.
- R7: When both slots of a cycle write the same register, the register ends up waiting on slot 1's tag, and only slot 1's result commits to it.
- R8: A broadcast changes a register, and raises `cmt_en` on its bus, only if that register's pending tag equals the broadcast tag. A stale result leaves `cmt_en` low.
- R9: Each unit starts at most one operation per cycle, and among ready stations of one kind the lowest-numbered station goes first.
- R10: An add result and a multiply result can both commit in the same cycle, one per bus.
- R11: A station stays occupied until its result is broadcast. It is free for dispatch from the cycle after that broadcast, and not during the broadcast cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 2 | Per-slot instruction valid (bit 0 is the older slot) |
| in_op | input | 2 | Per-slot operation: 0 add, 1 multiply |
| in_dst | input | 2 x RW | Per-slot destination register |
| in_src1 | input | 2 x RW | Per-slot first source register |
| in_src2 | input | 2 x RW | Per-slot second source register |
| taken | output | 2 | Per-slot dispatch accepted this cycle |
| stall | output | 1 | A valid slot was refused this cycle |
| cmt_en | output | 2 | Per-bus register write performed |
| cmt_reg | output | 2 x RW | Per-bus destination register of the broadcast |
| cmt_data | output | 2 x DW | Per-bus broadcast value |

## Verification
`taken` and `stall` are combinational in the dispatch cycle. An add with ready operands is due on bus 0 two cycles after it is dispatched, and a multiply is due on bus 1 three cycles after. A dependent operation is due its own latency after the cycle its producer's tag appears on a bus. The stimulus table holds one row per clock cycle, so each expected commit is written into the row of the cycle it is due. Inputs change just after the rising edge, and every output is compared at the falling edge of the same cycle. An early or late result therefore lands in a row that expects something different.

// File: rtl/tomo_pkg.sv
`timescale 1ns/1ps
package tomo_pkg;
    parameter int DW   = 16;
    parameter int NREG = 8;
    parameter int RW   = $clog2(NREG);
    parameter int NADD = 2;
    parameter int NMUL = 2;
    parameter int NRS  = NADD + NMUL;
    parameter int TW   = $clog2(NRS + 1);
    parameter int NBUS = 2;

    typedef logic [TW-1:0] tag_t;
    typedef logic [DW-1:0] word_t;
    typedef logic [RW-1:0] reg_t;

    // operand: either a value (rdy) or the tag of its producer
    typedef struct packed { logic rdy; tag_t tag; word_t val; } opnd_t;
    // reservation station entry
    typedef struct packed { logic busy; logic issued; reg_t dst; opnd_t a; opnd_t b; } slot_t;
    // result travelling down a unit and onto a bus
    typedef struct packed { logic vld; tag_t tag; reg_t dst; word_t val; } res_t;
    // register status entry
    typedef struct packed { logic busy; tag_t tag; word_t val; } rstat_t;

    function automatic opnd_t snoop(opnd_t o, res_t [NBUS-1:0] bus);
        opnd_t r = o;
        for (int b = 0; b < NBUS; b++)
            if (!o.rdy && bus[b].vld && bus[b].tag == o.tag) begin
                r.rdy = 1'b1;
                r.val = bus[b].val;
            end
        return r;
    endfunction

    function automatic opnd_t fetch(rstat_t e, res_t [NBUS-1:0] bus);
        opnd_t o;
        o.rdy = !e.busy;
        o.tag = e.busy ? e.tag : '0;
        o.val = e.busy ? '0 : e.val;
        return snoop(o, bus);
    endfunction
endpackage

// File: rtl/tomo_fu_pipe.sv
`timescale 1ns/1ps
module tomo_fu_pipe
    import tomo_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  res_t din,
    output res_t dout
);
    res_t st [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++) st[k] <= '0;
        end else begin
            st[0] <= din;
            for (int k = 1; k < LAT; k++) st[k] <= st[k-1];
        end
    end

    assign dout = st[LAT-1];
endmodule

// File: rtl/tomo_rs_bank.sv
`timescale 1ns/1ps
module tomo_rs_bank
    import tomo_pkg::*;
#(
    parameter int N      = 2,
    parameter int BASE   = 0,
    parameter bit IS_MUL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      wr0,
    input  logic [N-1:0]      wr1,
    input  slot_t             ent0,
    input  slot_t             ent1,
    input  res_t [NBUS-1:0]   bus,
    output logic [N-1:0]      free,
    output res_t              iss
);
    slot_t q   [N];
    slot_t eff [N];
    logic [N-1:0] rdy, grant, done, busy_v, issued_v;

    // effective view: stored entry woken by this cycle's buses, or the entry arriving now
    always_comb begin
        for (int i = 0; i < N; i++) begin
            eff[i]   = q[i];
            eff[i].a = snoop(q[i].a, bus);
            eff[i].b = snoop(q[i].b, bus);
            if (wr0[i]) eff[i] = ent0;
            if (wr1[i]) eff[i] = ent1;
            rdy[i] = eff[i].busy && !eff[i].issued && eff[i].a.rdy && eff[i].b.rdy;
        end
        grant = '0;
        iss   = '0;
        for (int i = 0; i < N; i++)
            if (rdy[i] && grant == '0) begin
                grant[i] = 1'b1;
                iss.vld  = 1'b1;
                iss.tag  = tag_t'(BASE + i + 1);
                iss.dst  = eff[i].dst;
                iss.val  = IS_MUL ? word_t'(eff[i].a.val * eff[i].b.val)
                                  : word_t'(eff[i].a.val + eff[i].b.val);
            end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            done[i] = 1'b0;
            for (int b = 0; b < NBUS; b++)
                if (bus[b].vld && bus[b].tag == tag_t'(BASE + i + 1)) done[i] = 1'b1;
            busy_v[i]   = q[i].busy;
            issued_v[i] = q[i].issued;
            free[i]     = !q[i].busy;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                q[i] <= '0;
            end else begin
                q[i] <= eff[i];
                if (grant[i]) q[i].issued <= 1'b1;
                if (q[i].busy && done[i]) q[i].busy <= 1'b0;
            end
        end
    end

    // R2: dispatch only ever targets an unoccupied station
    p_write_free_r2: assert property (@(posedge clk) disable iff (rst)
        ((wr0 | wr1) & busy_v) == '0);
    // R11: a station's tag comes back on a bus only after that station started executing
    p_free_after_issue_r11: assert property (@(posedge clk) disable iff (rst)
        (done & busy_v & ~issued_v) == '0);
endmodule

// File: rtl/tomo_core.sv
`timescale 1ns/1ps
module tomo_core
    import tomo_pkg::*;
#(
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          in_vld,
    input  logic [1:0]          in_op,
    input  logic [1:0][RW-1:0]  in_dst,
    input  logic [1:0][RW-1:0]  in_src1,
    input  logic [1:0][RW-1:0]  in_src2,
    output logic [1:0]          taken,
    output logic                stall,
    output logic [1:0]          cmt_en,
    output logic [1:0][RW-1:0]  cmt_reg,
    output logic [1:0][DW-1:0]  cmt_data
);
    localparam logic [NRS-1:0] MUL_MASK = {{NMUL{1'b1}}, {NADD{1'b0}}};

    rstat_t            rf [NREG];
    res_t [NBUS-1:0]   bus;
    res_t              add_iss, mul_iss;
    logic [NADD-1:0]   add_free;
    logic [NMUL-1:0]   mul_free;
    logic [NRS-1:0]    free_all, avail0, avail1, pick0, pick1;
    tag_t              tag0, tag1;
    logic              ok0, ok1;
    slot_t             ent0, ent1;

    assign free_all = {mul_free, add_free};

    // station allocation, in program order
    always_comb begin
        pick0 = '0; pick1 = '0; tag0 = '0; tag1 = '0; ok0 = 1'b0; ok1 = 1'b0;
        avail0 = free_all & (in_op[0] ? MUL_MASK : ~MUL_MASK);
        if (in_vld[0])
            for (int i = 0; i < NRS; i++)
                if (avail0[i] && !ok0) begin
                    pick0[i] = 1'b1; tag0 = tag_t'(i + 1); ok0 = 1'b1;
                end
        avail1 = free_all & ~pick0 & (in_op[1] ? MUL_MASK : ~MUL_MASK);
        if (in_vld[1] && (ok0 || !in_vld[0]))
            for (int i = 0; i < NRS; i++)
                if (avail1[i] && !ok1) begin
                    pick1[i] = 1'b1; tag1 = tag_t'(i + 1); ok1 = 1'b1;
                end
    end

    assign taken = {ok1, ok0};
    assign stall = (in_vld[0] && !ok0) || (in_vld[1] && !ok1);

    // operand capture; slot 1 sees slot 0's destination tag
    always_comb begin
        ent0        = '0;
        ent0.busy   = 1'b1;
        ent0.dst    = in_dst[0];
        ent0.a      = fetch(rf[in_src1[0]], bus);
        ent0.b      = fetch(rf[in_src2[0]], bus);
        ent1        = '0;
        ent1.busy   = 1'b1;
        ent1.dst    = in_dst[1];
        ent1.a      = fetch(rf[in_src1[1]], bus);
        ent1.b      = fetch(rf[in_src2[1]], bus);
        if (ok0 && in_src1[1] == in_dst[0]) ent1.a = '{rdy: 1'b0, tag: tag0, val: '0};
        if (ok0 && in_src2[1] == in_dst[0]) ent1.b = '{rdy: 1'b0, tag: tag0, val: '0};
    end

    tomo_rs_bank #(.N(NADD), .BASE(0), .IS_MUL(1'b0)) u_add_rs (
        .clk(clk), .rst(rst),
        .wr0(pick0[NADD-1:0]), .wr1(pick1[NADD-1:0]),
        .ent0(ent0), .ent1(ent1), .bus(bus),
        .free(add_free), .iss(add_iss)
    );

    tomo_rs_bank #(.N(NMUL), .BASE(NADD), .IS_MUL(1'b1)) u_mul_rs (
        .clk(clk), .rst(rst),
        .wr0(pick0[NRS-1:NADD]), .wr1(pick1[NRS-1:NADD]),
        .ent0(ent0), .ent1(ent1), .bus(bus),
        .free(mul_free), .iss(mul_iss)
    );

    tomo_fu_pipe #(.LAT(LAT_ADD)) u_add_pipe (.clk(clk), .rst(rst), .din(add_iss), .dout(bus[0]));
    tomo_fu_pipe #(.LAT(LAT_MUL)) u_mul_pipe (.clk(clk), .rst(rst), .din(mul_iss), .dout(bus[1]));

    // commit write only when the register still waits on this producer
    always_comb begin
        for (int b = 0; b < NBUS; b++) begin
            cmt_en[b]   = bus[b].vld && rf[bus[b].dst].busy && rf[bus[b].dst].tag == bus[b].tag;
            cmt_reg[b]  = bus[b].dst;
            cmt_data[b] = bus[b].val;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (rst) begin
                rf[r] <= '{busy: 1'b0, tag: '0, val: word_t'(r)};
            end else begin
                for (int b = 0; b < NBUS; b++)
                    if (cmt_en[b] && cmt_reg[b] == reg_t'(r)) begin
                        rf[r].val  <= cmt_data[b];
                        rf[r].busy <= 1'b0;
                    end
                if (ok0 && in_dst[0] == reg_t'(r)) begin
                    rf[r].busy <= 1'b1; rf[r].tag <= tag0;
                end
                if (ok1 && in_dst[1] == reg_t'(r)) begin
                    rf[r].busy <= 1'b1; rf[r].tag <= tag1;
                end
            end
        end
    end

    // R2: the younger slot never overtakes a refused older slot
    p_in_order_r2: assert property (@(posedge clk) disable iff (rst)
        (in_vld[0] && !taken[0]) |-> !taken[1]);
    // R10: the two buses never carry the same producer
    p_bus_distinct_r10: assert property (@(posedge clk) disable iff (rst)
        (bus[0].vld && bus[1].vld) |-> (bus[0].tag != bus[1].tag));
    // R10: bus 0 carries only add-station tags
    p_bus_class_r10: assert property (@(posedge clk) disable iff (rst)
        bus[0].vld |-> (bus[0].tag != '0 && bus[0].tag <= tag_t'(NADD)));
    // R7: a pending register always names a real producer
    for (genvar g = 0; g < NREG; g++) begin : g_rf_chk
        p_busy_tag_r7: assert property (@(posedge clk) disable iff (rst)
            rf[g].busy |-> (rf[g].tag != '0));
    end
endmodule

// File: tb/tomo_core_test.sv
`timescale 1ns/1ps
module tomo_core_test;
    import tomo_pkg::*;

    typedef struct packed {
        logic [1:0] vld;
        logic op0; reg_t d0; reg_t a0; reg_t b0;
        logic op1; reg_t d1; reg_t a1; reg_t b1;
        logic [1:0] tk; logic st;
        logic e0; reg_t r0; word_t x0;
        logic e1; reg_t r1; word_t x1;
        logic [23:0] rq;
    } vec_t;

    function automatic vec_t mk(int v, int o0, int d0, int a0, int b0,
                                int o1, int d1, int a1, int b1, int tk, int st,
                                int e0, int r0, int x0, int e1, int r1, int x1,
                                logic [23:0] rq);
        vec_t t;
        t.vld = 2'(v); t.op0 = 1'(o0); t.d0 = reg_t'(d0); t.a0 = reg_t'(a0); t.b0 = reg_t'(b0);
        t.op1 = 1'(o1); t.d1 = reg_t'(d1); t.a1 = reg_t'(a1); t.b1 = reg_t'(b1);
        t.tk = 2'(tk); t.st = 1'(st);
        t.e0 = 1'(e0); t.r0 = reg_t'(r0); t.x0 = word_t'(x0);
        t.e1 = 1'(e1); t.r1 = reg_t'(r1); t.x1 = word_t'(x1);
        t.rq = rq;
        return t;
    endfunction

    // one row per cycle: inputs, expected taken/stall, expected commits on bus 0 and bus 1
    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        mk(3, 0,1,2,3, 1,4,1,5, 3,0, 0,0,0,     0,0,0,     "R6 "),
        mk(3, 0,6,6,7, 1,7,2,3, 3,0, 0,0,0,     0,0,0,     "R2 "),
        mk(3, 0,0,0,0, 0,5,1,1, 0,1, 1,1,5,     0,0,0,     "R11"),
        mk(3, 0,0,0,0, 0,5,1,1, 1,1, 1,6,13,    0,0,0,     "R11"),
        mk(3, 0,5,1,1, 1,2,6,6, 1,1, 0,0,0,     1,7,6,     "R4 "),
        mk(1, 1,2,6,6, 0,0,0,0, 1,0, 1,0,0,     1,4,25,    "R5 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 1,5,10,    0,0,0,     "R3 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     0,0,0,     "R4 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     1,2,169,   "R4 "),
        mk(3, 0,3,1,5, 0,3,3,3, 3,0, 0,0,0,     0,0,0,     "R7 "),
        mk(3, 1,0,4,4, 1,1,6,7, 3,0, 0,0,0,     0,0,0,     "R9 "),
        mk(1, 0,7,2,2, 0,0,0,0, 0,1, 0,0,0,     0,0,0,     "R8 "),
        mk(1, 0,7,2,2, 0,0,0,0, 1,0, 0,0,0,     0,0,0,     "R11"),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 1,3,30,    1,0,625,   "R10"),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 1,7,338,   1,1,78,    "R9 "),
        mk(1, 1,5,0,0, 0,0,0,0, 1,0, 0,0,0,     0,0,0,     "R2 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     0,0,0,     "R4 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     0,0,0,     "R4 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     1,5,62945, "R4 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     0,0,0,     "R4 "),
        mk(2, 0,0,0,0, 0,4,7,7, 2,0, 0,0,0,     0,0,0,     "R2 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     0,0,0,     "R3 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 1,4,676,   0,0,0,     "R3 "),
        mk(0, 0,0,0,0, 0,0,0,0, 0,0, 0,0,0,     0,0,0,     "R3 ")
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]         in_vld = '0;
    logic [1:0]         in_op  = '0;
    logic [1:0][RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [1:0]         taken;
    logic               stall;
    logic [1:0]         cmt_en;
    logic [1:0][RW-1:0] cmt_reg;
    logic [1:0][DW-1:0] cmt_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tomo_core uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_dst(in_dst),
        .in_src1(in_src1), .in_src2(in_src2), .taken(taken), .stall(stall),
        .cmt_en(cmt_en), .cmt_reg(cmt_reg), .cmt_data(cmt_data)
    );

    task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t t);
        in_vld     = t.vld;
        in_op      = {t.op1, t.op0};
        in_dst     = {t.d1, t.d0};
        in_src1    = {t.a1, t.a0};
        in_src2    = {t.b1, t.b0};
    endtask

    task automatic idle();
        in_vld = '0; in_op = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
    endtask

    task automatic check_bus(input string rq, input int b, input logic e, input reg_t r, input word_t x);
        cmp(rq, $sformatf("bus%0d commit enable", b), 32'(cmt_en[b]), 32'(e));
        if (e) begin
            cmp(rq, $sformatf("bus%0d register", b), 32'(cmt_reg[b]), 32'(r));
            cmp(rq, $sformatf("bus%0d value", b), 32'(cmt_data[b]), 32'(x));
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset: nothing taken, no stall, no commits
        cmp("R1", "taken", 32'(taken), 32'd0);
        cmp("R1", "stall", 32'(stall), 32'd0);
        cmp("R1", "commit enables", 32'(cmt_en), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #1 apply(TBL[i]);
            @(negedge clk);
            cmp(string'(TBL[i].rq), $sformatf("row %0d taken", i), 32'(taken), 32'(TBL[i].tk));
            cmp(string'(TBL[i].rq), $sformatf("row %0d stall", i), 32'(stall), 32'(TBL[i].st));
            check_bus(string'(TBL[i].rq), 0, TBL[i].e0, TBL[i].r0, TBL[i].x0);
            check_bus(string'(TBL[i].rq), 1, TBL[i].e1, TBL[i].r1, TBL[i].x1);
        end

        // R1: reset in the middle of work discards pending results and pending producers
        @(posedge clk);
        #1 begin
            in_vld = 2'b01; in_op = 2'b00;
            in_dst = {reg_t'(0), reg_t'(1)}; in_src1 = {reg_t'(0), reg_t'(1)}; in_src2 = {reg_t'(0), reg_t'(1)};
        end
        @(negedge clk);
        cmp("R1", "pre-reset dispatch taken", 32'(taken), 32'd1);
        @(posedge clk);
        #1 begin idle(); rst = 1'b1; end
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cmp("R1", "no broadcast after reset", 32'(cmt_en), 32'd0);
            @(posedge clk);
            #1;
        end
        // add r2 = r2 + r1 -> 2 + 1 = 3 with both registers back at their index values
        in_vld = 2'b01; in_op = 2'b00;
        in_dst = {reg_t'(0), reg_t'(2)}; in_src1 = {reg_t'(0), reg_t'(2)}; in_src2 = {reg_t'(0), reg_t'(1)};
        @(negedge clk);
        cmp("R1", "post-reset dispatch taken", 32'(taken), 32'd1);
        @(posedge clk);
        #1 idle();
        @(negedge clk);
        check_bus("R3", 0, 1'b0, '0, '0);
        @(posedge clk);
        @(negedge clk);
        check_bus("R1", 0, 1'b1, reg_t'(2), word_t'(3));

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule